// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the control sequencer that carries a small 16-bit processor from an instruction boundary into an interrupt handler. It watches three sources. The first is a maskable request level from an external interrupt controller. The second is a non-maskable request, which is edge-triggered. The third is a software-interrupt request issued by the executing instruction, which carries an 8-bit type. When a source is taken, the sequencer finds the 8-bit interrupt type. It then saves the processor context on the stack and clears the interrupt-enable flag. Last, it loads a new code segment and instruction pointer from the vector table.

The core presents its architectural state (flags, code segment, instruction pointer, stack pointer) and raises a boundary strobe once the current instruction has finished. The sequencer drives a simple memory port that holds each request until the memory grants it. It also drives an acknowledge handshake toward the interrupt controller. When the sequence ends, it reports the new instruction pointer, code segment, stack pointer and flags, together with a one-cycle completion pulse.

Top module: `intseq_top`

## Requirements
- R1: A request is taken only in a cycle where `boundary_i` is high and `busy_o` is low. Software requests and rising edges of `nmi_i` stay pending across any number of cycles until a boundary takes them.
- R2: A maskable request (`irq_i` high) is taken only when bit 9 (the interrupt-enable bit) of `flags_i` is 1. Non-maskable and software requests are taken whatever the value of that bit.
- R3: For a maskable request, `ack_req_o` stays high until a cycle with `ack_rdy_i` high. The interrupt type is the value of `ack_type_i` in that cycle.
- R4: A non-maskable request always uses type 2. A software request uses its `swi_type_i`. Neither of them raises `ack_req_o`.
- R5: The context is saved by three 16-bit writes (`mem_we_o`=1). They are flags to SP-2, then code segment to SP-4, then instruction pointer to SP-6, with 16-bit wrap-around. `new_sp_o` ends at SP-6.
- R6: At completion, `new_flags_o` equals the captured flags with bit 9 cleared and all other bits unchanged.
- R7: After the writes come four byte reads (`mem_we_o`=0) at type×4, +1, +2, +3, in ascending order. The new instruction pointer is {byte1,byte0} and the new code segment is {byte3,byte2}.
- R8: At the same boundary, a non-maskable request wins over a software request, and a software request wins over a maskable one. A source that loses stays pending for a later boundary.
- R9: `done_o` is high for exactly one cycle at the end of each sequence, and `busy_o` is high during that cycle.
- R10: While `mem_req_o` is high and `mem_rdy_i` is low, the address and write data hold steady and the request stays raised.
- R11: After reset, `busy_o`, `done_o`, `ack_req_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boundary_i | input | 1 | Current instruction has finished |
| irq_i | input | 1 | Maskable request level |
| nmi_i | input | 1 | Non-maskable request, rising edge pends it |
| swi_i | input | 1 | Software interrupt request pulse |
| swi_type_i | input | 8 | Type carried by the software request |
| flags_i | input | 16 | Current flags word, bit 9 is interrupt enable |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Return instruction pointer |
| sp_i | input | 16 | Current stack pointer |
| ack_req_o | output | 1 | Acknowledge cycle toward the controller |
| ack_rdy_i | input | 1 | Controller presents the type |
| ack_type_i | input | 8 | Type returned by the controller |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1: 16-bit write, 0: byte read |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 8 | Read byte |
| mem_rdy_i | input | 1 | Memory accepts the request this cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| new_ip_o | output | 16 | Handler instruction pointer |
| new_cs_o | output | 16 | Handler code segment |
| new_sp_o | output | 16 | Stack pointer after the saves |
| new_flags_o | output | 16 | Flags with interrupt enable cleared |

## Verification
Each of the three sources is driven on its own, with several types, so the choice between the acknowledged type, the fixed non-maskable type and the software-supplied type shows up directly in the vector addresses. Flag words both with and without the enable bit separate the masking rule from the ungated sources. A stack pointer of 2 checks wrap-around, and type 255 checks the top of the table. Alternating ready stalls on the memory and acknowledge paths test that requests hold steady. All three sources raised at one boundary, then taken over three boundaries, show both the priority order and the holding of the losers.

// File: rtl/intseq_pkg.sv
package intseq_pkg;

  localparam int WORD_W    = 16;
  localparam int TYPE_W    = 8;
  localparam int PUSH_LAST = 2;
  localparam int VEC_LAST  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_PUSH,
    ST_VEC,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_MASK,
    SRC_NMI,
    SRC_SOFT
  } src_e;

  // byte address of vector byte idx for a given type: type*4 + idx
  function automatic logic [WORD_W-1:0] vec_byte_addr(input logic [TYPE_W-1:0] t,
                                                      input logic [1:0] idx);
    return {6'd0, t, 2'b00} + {14'd0, idx};
  endfunction

  // word saved by push number idx: flags, then code segment, then pointer
  function automatic logic [WORD_W-1:0] push_word(input logic [1:0] idx,
                                                  input logic [WORD_W-1:0] f,
                                                  input logic [WORD_W-1:0] c,
                                                  input logic [WORD_W-1:0] i);
    case (idx)
      2'd0:    return f;
      2'd1:    return c;
      default: return i;
    endcase
  endfunction

endpackage

// File: rtl/intseq_arb.sv
module intseq_arb
  import intseq_pkg::*;
#(
  parameter logic [TYPE_W-1:0] NMI_TYPE = 8'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic              swi_i,
  input  logic [TYPE_W-1:0] swi_type_i,
  input  logic              irq_i,
  input  logic              ie_i,
  input  logic              take_i,
  output logic              grant_o,
  output src_e              src_o,
  output logic [TYPE_W-1:0] type_o
);

  logic              nmi_q;
  logic              nmi_pend;
  logic              swi_pend;
  logic [TYPE_W-1:0] swi_type_q;

  logic nmi_edge, nmi_hit, swi_hit, irq_hit;
  logic nmi_taken, swi_taken;

  assign nmi_edge = nmi_i & ~nmi_q;
  assign nmi_hit  = nmi_pend | nmi_edge;
  assign swi_hit  = swi_pend | swi_i;
  assign irq_hit  = irq_i & ie_i;

  always_comb begin
    src_o  = SRC_NONE;
    type_o = '0;
    if (nmi_hit) begin
      src_o  = SRC_NMI;
      type_o = NMI_TYPE;
    end else if (swi_hit) begin
      src_o  = SRC_SOFT;
      type_o = swi_i ? swi_type_i : swi_type_q;
    end else if (irq_hit) begin
      src_o  = SRC_MASK;
    end
  end

  assign grant_o   = take_i && (src_o != SRC_NONE);
  assign nmi_taken = grant_o && (src_o == SRC_NMI);
  assign swi_taken = grant_o && (src_o == SRC_SOFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q      <= 1'b0;
      nmi_pend   <= 1'b0;
      swi_pend   <= 1'b0;
      swi_type_q <= '0;
    end else begin
      nmi_q    <= nmi_i;
      nmi_pend <= nmi_hit & ~nmi_taken;
      swi_pend <= swi_hit & ~swi_taken;
      if (swi_i) swi_type_q <= swi_type_i;
    end
  end

  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend && !take_i |=> nmi_pend); // R1

  AST_SOFT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    swi_pend && !take_i |=> swi_pend); // R1

  AST_NMI_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o && nmi_pend |-> type_o == NMI_TYPE); // R8

endmodule

// File: rtl/intseq_core.sv
module intseq_core
  import intseq_pkg::*;
#(
  parameter int IE_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  src_e              start_src_i,
  input  logic [TYPE_W-1:0] start_type_i,
  input  logic [WORD_W-1:0] flags_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic              ack_req_o,
  input  logic              ack_rdy_i,
  input  logic [TYPE_W-1:0] ack_type_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              mem_rdy_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] new_ip_o,
  output logic [WORD_W-1:0] new_cs_o,
  output logic [WORD_W-1:0] new_sp_o,
  output logic [WORD_W-1:0] new_flags_o
);

  seq_state_e        st;
  logic [1:0]        cnt;
  src_e              src_r;
  logic [TYPE_W-1:0] type_r;
  logic [WORD_W-1:0] flags_r, cs_r, ip_r, sp_r;
  logic [31:0]       vec_r;

  // named internal events
  logic ack_fire, push_fire, vec_fire, last_push, last_vec;
  logic [WORD_W-1:0] push_addr, vec_addr;

  assign ack_fire  = (st == ST_ACK) && ack_rdy_i;
  assign push_fire = (st == ST_PUSH) && mem_rdy_i;
  assign vec_fire  = (st == ST_VEC) && mem_rdy_i;
  assign last_push = push_fire && (cnt == 2'(PUSH_LAST));
  assign last_vec  = vec_fire && (cnt == 2'(VEC_LAST));
  assign push_addr = sp_r - 16'd2;
  assign vec_addr  = vec_byte_addr(type_r, cnt);

  assign busy_o      = (st != ST_IDLE);
  assign done_o      = (st == ST_DONE);
  assign ack_req_o   = (st == ST_ACK);
  assign mem_req_o   = (st == ST_PUSH) || (st == ST_VEC);
  assign mem_we_o    = (st == ST_PUSH);
  assign mem_addr_o  = (st == ST_PUSH) ? push_addr : vec_addr;
  assign mem_wdata_o = push_word(cnt, flags_r, cs_r, ip_r);
  assign new_ip_o    = vec_r[15:0];
  assign new_cs_o    = vec_r[31:16];
  assign new_sp_o    = sp_r;
  assign new_flags_o = flags_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      src_r   <= SRC_NONE;
      type_r  <= '0;
      flags_r <= '0;
      cs_r    <= '0;
      ip_r    <= '0;
      sp_r    <= '0;
      vec_r   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            src_r   <= start_src_i;
            type_r  <= start_type_i;
            flags_r <= flags_i;
            cs_r    <= cs_i;
            ip_r    <= ip_i;
            sp_r    <= sp_i;
            cnt     <= '0;
            st      <= (start_src_i == SRC_MASK) ? ST_ACK : ST_PUSH;
          end
        end
        ST_ACK: begin
          if (ack_fire) begin
            type_r <= ack_type_i;
            st     <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (push_fire) begin
            sp_r <= push_addr;
            cnt  <= cnt + 2'd1;
            if (last_push) begin
              cnt             <= '0;
              flags_r[IE_BIT] <= 1'b0;
              st              <= ST_VEC;
            end
          end
        end
        ST_VEC: begin
          if (vec_fire) begin
            vec_r[cnt*8 +: 8] <= mem_rdata_i;
            cnt               <= cnt + 2'd1;
            if (last_vec) st <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o); // R9

  AST_IE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !new_flags_o[IE_BIT]); // R6

  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> sp_r == $past(mem_addr_o)); // R5

  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_we_o |-> mem_addr_o[15:10] == 6'd0); // R7

  AST_ACK_MASK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |-> src_r == SRC_MASK); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)); // R10

endmodule

// File: rtl/intseq_top.sv
module intseq_top
  import intseq_pkg::*;
#(
  parameter int                IE_BIT   = 9,
  parameter logic [TYPE_W-1:0] NMI_TYPE = 8'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary_i,
  input  logic        irq_i,
  input  logic        nmi_i,
  input  logic        swi_i,
  input  logic [7:0]  swi_type_i,
  input  logic [15:0] flags_i,
  input  logic [15:0] cs_i,
  input  logic [15:0] ip_i,
  input  logic [15:0] sp_i,
  output logic        ack_req_o,
  input  logic        ack_rdy_i,
  input  logic [7:0]  ack_type_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [15:0] mem_addr_o,
  output logic [15:0] mem_wdata_o,
  input  logic [7:0]  mem_rdata_i,
  input  logic        mem_rdy_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] new_ip_o,
  output logic [15:0] new_cs_o,
  output logic [15:0] new_sp_o,
  output logic [15:0] new_flags_o
);

  logic              take;
  logic              grant;
  src_e              grant_src;
  logic [TYPE_W-1:0] grant_type;

  assign take = boundary_i & ~busy_o;

  intseq_arb #(.NMI_TYPE(NMI_TYPE)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .nmi_i      (nmi_i),
    .swi_i      (swi_i),
    .swi_type_i (swi_type_i),
    .irq_i      (irq_i),
    .ie_i       (flags_i[IE_BIT]),
    .take_i     (take),
    .grant_o    (grant),
    .src_o      (grant_src),
    .type_o     (grant_type)
  );

  intseq_core #(.IE_BIT(IE_BIT)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (grant),
    .start_src_i  (grant_src),
    .start_type_i (grant_type),
    .flags_i      (flags_i),
    .cs_i         (cs_i),
    .ip_i         (ip_i),
    .sp_i         (sp_i),
    .ack_req_o    (ack_req_o),
    .ack_rdy_i    (ack_rdy_i),
    .ack_type_i   (ack_type_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i),
    .mem_rdy_i    (mem_rdy_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .new_ip_o     (new_ip_o),
    .new_cs_o     (new_cs_o),
    .new_sp_o     (new_sp_o),
    .new_flags_o  (new_flags_o)
  );

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> busy_o); // R1

  AST_MASK_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req_o) |-> $past(flags_i[IE_BIT])); // R2

endmodule

// File: tb/tb_intseq_top.sv
module tb_intseq_top;

  localparam int K_MASK = 0;
  localparam int K_NMI  = 1;
  localparam int K_SWI  = 2;

  // {kind[74:73], type[72:65], flags[64:49], cs[48:33], ip[32:17], sp[16:1], stall[0]}
  localparam int NVEC = 6;
  localparam logic [74:0] TAB [NVEC] = '{
    {2'd0, 8'h08, 16'h0202, 16'h1234, 16'h0100, 16'hFFF0, 1'b0},
    {2'd1, 8'h77, 16'h0002, 16'hF000, 16'hABCD, 16'h8000, 1'b1},
    {2'd2, 8'h21, 16'h0246, 16'h2000, 16'h0005, 16'h0002, 1'b0},
    {2'd2, 8'hFF, 16'h0200, 16'h0000, 16'hFFFF, 16'h1000, 1'b1},
    {2'd0, 8'h00, 16'hFFFF, 16'h5555, 16'hAAAA, 16'h0400, 1'b1},
    {2'd2, 8'h00, 16'h0000, 16'h0101, 16'h0202, 16'h0300, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 1'b0, irq = 1'b0, nmi = 1'b0, swi = 1'b0;
  logic [7:0] swi_type = '0, ack_type = '0;
  logic [15:0] flags = '0, cs = '0, ip = '0, sp = '0;
  logic ack_req, ack_rdy, mem_req, mem_we, mem_rdy, busy, done;
  logic [15:0] mem_addr, mem_wdata, new_ip, new_cs, new_sp, new_flags;
  logic [7:0] mem_rdata;
  logic stall = 1'b0, tog = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  int nw = 0, nr = 0, nack = 0, stab_err = 0;
  logic [15:0] wa [4];
  logic [15:0] wd [4];
  logic [15:0] ra [5];
  logic held = 1'b0;
  logic [15:0] h_addr, h_data;

  always #5 clk = ~clk;

  function automatic logic [7:0] mb(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ {6'd0, a[9:8]} ^ 8'h5C;
  endfunction

  assign mem_rdata = mb(mem_addr);
  assign mem_rdy   = stall ? tog : 1'b1;
  assign ack_rdy   = tog;

  intseq_top dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .irq_i(irq), .nmi_i(nmi),
    .swi_i(swi), .swi_type_i(swi_type), .flags_i(flags), .cs_i(cs), .ip_i(ip),
    .sp_i(sp), .ack_req_o(ack_req), .ack_rdy_i(ack_rdy), .ack_type_i(ack_type),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy),
    .busy_o(busy), .done_o(done), .new_ip_o(new_ip), .new_cs_o(new_cs),
    .new_sp_o(new_sp), .new_flags_o(new_flags)
  );

  always @(posedge clk) begin
    tog <= ~tog;
    cyc <= cyc + 1;
    if (held && (!mem_req || mem_addr != h_addr || mem_wdata != h_data)) stab_err <= stab_err + 1;
    held   <= mem_req && !mem_rdy;
    h_addr <= mem_addr;
    h_data <= mem_wdata;
    if (ack_req && ack_rdy) nack <= nack + 1;
    if (mem_req && mem_rdy) begin
      if (mem_we) begin
        if (nw < 4) begin wa[nw] <= mem_addr; wd[nw] <= mem_wdata; end
        nw <= nw + 1;
      end else begin
        if (nr < 5) ra[nr] <= mem_addr;
        nr <= nr + 1;
      end
    end
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    nw = 0; nr = 0; nack = 0; stab_err = 0;
  endtask

  task automatic pulse_boundary();
    @(negedge clk); boundary = 1'b1;
    @(negedge clk); boundary = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk(done, tag, {31'd0, done}, 32'd1);
  endtask

  task automatic check_entry(input logic [7:0] etype, input logic [15:0] f, input logic [15:0] c,
                             input logic [15:0] i, input logic [15:0] s, input int eack, input string tag);
    logic [15:0] va = {6'd0, etype, 2'b00};
    @(negedge clk);
    chk(done == 1'b0, {tag, " R9 pulse ends"}, {31'd0, done}, 32'd0);
    chk(nack == eack, {tag, " R3 R4 ack count"}, nack, eack);
    chk(nw == 3, {tag, " R5 write count"}, nw, 3);
    chk(wa[0] == s - 16'd2 && wd[0] == f, {tag, " R5 flags push"}, {wa[0], wd[0]}, {s - 16'd2, f});
    chk(wa[1] == s - 16'd4 && wd[1] == c, {tag, " R5 cs push"}, {wa[1], wd[1]}, {s - 16'd4, c});
    chk(wa[2] == s - 16'd6 && wd[2] == i, {tag, " R5 ip push"}, {wa[2], wd[2]}, {s - 16'd6, i});
    chk(new_sp == s - 16'd6, {tag, " R5 new sp"}, new_sp, s - 16'd6);
    chk(new_flags == (f & 16'hFDFF), {tag, " R6 flags"}, new_flags, f & 16'hFDFF);
    chk(nr == 4 && ra[0] == va && ra[1] == va + 1 && ra[2] == va + 2 && ra[3] == va + 3,
        {tag, " R7 vector reads"}, {ra[0], ra[3]}, {va, va + 16'd3});
    chk(new_ip == {mb(va + 1), mb(va)}, {tag, " R7 new ip"}, new_ip, {mb(va + 1), mb(va)});
    chk(new_cs == {mb(va + 3), mb(va + 2)}, {tag, " R7 new cs"}, new_cs, {mb(va + 3), mb(va + 2)});
    chk(stab_err == 0, {tag, " R10 stall hold"}, stab_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ack_req && !mem_req, "R11 reset outputs",
        {busy, done, ack_req, mem_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_req, "R11 idle after reset", {busy, mem_req}, 0);

    // table-driven entries
    for (int k = 0; k < NVEC; k++) begin
      logic [74:0] v = TAB[k];
      int kind = int'(v[74:73]);
      clear_log();
      stall = v[0]; flags = v[64:49]; cs = v[48:33]; ip = v[32:17]; sp = v[16:1];
      ack_type = v[72:65];
      if (kind == K_MASK) irq = 1'b1;
      if (kind == K_NMI) nmi = 1'b1;
      if (kind == K_SWI) begin swi = 1'b1; swi_type = v[72:65]; end
      @(negedge clk); swi = 1'b0;
      pulse_boundary();
      nmi = 1'b0;
      wait_done($sformatf("vec%0d R9 done", k));
      irq = 1'b0;
      check_entry(kind == K_NMI ? 8'd2 : v[72:65], v[64:49], v[48:33], v[32:17], v[16:1],
                  kind == K_MASK ? 1 : 0, $sformatf("vec%0d", k));
    end
    stall = 1'b0;

    // R2: masked request ignored when enable bit clear
    clear_log();
    flags = 16'h0000; irq = 1'b1;
    pulse_boundary();
    repeat (6) @(negedge clk);
    chk(!busy && nack == 0 && nw == 0, "R2 masked irq ignored", {busy, 8'(nack), 8'(nw)}, 0);
    irq = 1'b0;

    // R1: software request held without a boundary, then taken
    clear_log();
    flags = 16'h0200; cs = 16'h3000; ip = 16'h0040; sp = 16'h2000;
    swi = 1'b1; swi_type = 8'h10;
    @(negedge clk); swi = 1'b0;
    repeat (8) @(negedge clk);
    chk(!busy && nw == 0, "R1 held until boundary", {busy, 8'(nw)}, 0);
    pulse_boundary();
    wait_done("R1 held swi done");
    check_entry(8'h10, 16'h0200, 16'h3000, 16'h0040, 16'h2000, 0, "R1 held swi");

    // R8: all three at one boundary, taken over three boundaries
    flags = 16'h0200; cs = 16'h4444; ip = 16'h0888; sp = 16'h6000; ack_type = 8'h33;
    clear_log();
    irq = 1'b1; nmi = 1'b1; swi = 1'b1; swi_type = 8'h40;
    @(negedge clk); swi = 1'b0;
    pulse_boundary();
    wait_done("R8 first done");
    check_entry(8'd2, 16'h0200, 16'h4444, 16'h0888, 16'h6000, 0, "R8 nmi first");
    nmi = 1'b0;
    clear_log();
    pulse_boundary();
    wait_done("R8 second done");
    check_entry(8'h40, 16'h0200, 16'h4444, 16'h0888, 16'h6000, 0, "R8 swi second");
    clear_log();
    pulse_boundary();
    wait_done("R8 third done");
    check_entry(8'h33, 16'h0200, 16'h4444, 16'h0888, 16'h6000, 1, "R8 irq third");
    irq = 1'b0;

    // R1: boundary while busy does not start a second entry
    clear_log();
    nmi = 1'b1;
    pulse_boundary();
    nmi = 1'b0;
    @(negedge clk); boundary = 1'b1;
    wait_done("R1 busy boundary done");
    boundary = 1'b0;
    check_entry(8'd2, 16'h0200, 16'h4444, 16'h0888, 16'h6000, 0, "R1 busy boundary");
    repeat (4) @(negedge clk);
    chk(!busy && nw == 3, "R1 no re-entry", {busy, 8'(nw)}, 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule